// File: doc/BRIEF.md
# Dual-Channel Output Compare Unit

This block adds two output compare channels to a 16-bit free-running counter that sits outside it. Each channel holds a 16-bit compare value. When the counter reaches the point set by that value, the channel loads its programmed level into an output latch and raises a status flag. Software programs the unit through a byte-wide register bus. The compare values are written as high and low bytes. A control byte holds the per-channel output enables, the level bits and a shared interrupt enable. A strobe byte forces a level onto a pin at once, and a status byte holds the flags.

The counter's clock division is given as an input. With division by 2 or 4 the match fires while the counter equals the compare value. With division by 8, or with external clocking, it fires one count later. A mode input marks that one-pulse or PWM operation is active, and forcing is ignored while it is set. A waveform is shaped by changing the level bit after each match.

Register map (3-bit address): 0/1 channel 0 compare high/low, 2/3 channel 1 compare high/low, 4 control, 5 force strobes, 6 status. Control byte: bits 1:0 output enables, bits 3:2 level bits (channel 0 in the low bit of each pair), bit 7 interrupt enable. The force byte uses bits 1:0. The status byte holds the flags in bits 1:0.

Top module: `occ_unit`

## Requirements
- R1: After reset both compare values read 0xFFFF, both pins and the interrupt are low, all flags read 0 and neither channel is inhibited.
- R2: With `slow_clk_i` low, the first clock cycle in which `cnt_i` equals a channel's compare value sets that channel's flag (status bit = channel number) and loads its level bit into its pin latch; both are visible on the next cycle.
- R3: With `slow_clk_i` high, the match happens when `cnt_i` equals the compare value plus 1, modulo 2^16, so compare value 0xFFFF matches a count of 0x0000; a count equal to the compare value itself does not match.
- R4: Writing a channel's compare high byte (address 2·ch) blocks that channel's matching until its low byte (address 2·ch+1) is written.
- R5: While a channel's output enable (control bit ch) is clear, its pin reads 0 and its latch is not loaded, but a match still sets its flag.
- R6: Writing 1 to force bit ch (address 5) copies the channel's level bit (control bit 2+ch) to its enabled pin on the next cycle without setting the flag.
- R7: Force writes have no effect while `mode_lock_i` is high.
- R8: The force register always reads 0x00.
- R9: `irq_o` is high exactly when the interrupt enable (control bit 7) is set and at least one flag is set.
- R10: A flag clears only when a status read (`rd_en_i` with address 6) that saw it set is later followed by a write to that channel's low compare byte. A low-byte write without that read leaves it set.
- R11: A flag is set once per match window. Clearing it while the counter still matches does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Free-running counter value |
| slow_clk_i | input | 1 | High for division by 8 or external counter clock |
| mode_lock_i | input | 1 | One-pulse or PWM mode active; blocks forcing |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms flag clearing on status) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| ocmp_o | output | 2 | Compare output pins, bit = channel |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that captures it. Its effect on reads, pins and the interrupt appears from the following cycle. A counter value applied after an edge causes a match at the next edge, so the flag and pin update one cycle after the count is presented. The driver applies every stimulus just after a rising edge, waits out the edges this latency needs, and only then queues the expected value. The monitor compares at the falling edge, when all state has settled and no update is pending.

// File: rtl/occ_pkg.sv
`timescale 1ns/1ps
package occ_pkg;
  localparam int unsigned OCC_NCH = 2;
  localparam int unsigned OCC_CW  = 16;
  localparam int unsigned OCC_DW  = 8;
  localparam int unsigned OCC_AW  = 3;
  // register addresses after the compare byte pairs
  localparam int unsigned OCC_A_CTRL  = 2 * OCC_NCH;
  localparam int unsigned OCC_A_FORCE = 2 * OCC_NCH + 1;
  localparam int unsigned OCC_A_STAT  = 2 * OCC_NCH + 2;
endpackage

// File: rtl/occ_regs.sv
`timescale 1ns/1ps
module occ_regs
  import occ_pkg::*;
#(
  parameter int unsigned NCH = OCC_NCH,
  parameter int unsigned CW  = OCC_CW,
  parameter int unsigned DW  = OCC_DW,
  parameter int unsigned AW  = OCC_AW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [NCH-1:0]      flag_i,
  output logic [DW-1:0]       rdata_o,
  output logic [NCH-1:0][CW-1:0] cmp_o,
  output logic [NCH-1:0]      inhibit_o,
  output logic [NCH-1:0]      oe_o,
  output logic [NCH-1:0]      lvl_o,
  output logic                ie_o,
  output logic [NCH-1:0]      force_o,
  output logic [NCH-1:0]      clr_o
);
  localparam logic [AW-1:0] A_CTRL  = AW'(OCC_A_CTRL);
  localparam logic [AW-1:0] A_FORCE = AW'(OCC_A_FORCE);
  localparam logic [AW-1:0] A_STAT  = AW'(OCC_A_STAT);

  logic [NCH-1:0][CW-1:0] cmp_q, cmp_d;
  logic [NCH-1:0]         inh_q, inh_d;
  logic [NCH-1:0]         oe_q, oe_d, lvl_q, lvl_d;
  logic                   ie_q, ie_d;
  logic [NCH-1:0]         arm_q, arm_d;
  logic                   wr_ctrl, wr_force, rd_stat;

  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_force = wr_en_i && (addr_i == A_FORCE);
  assign rd_stat  = rd_en_i && (addr_i == A_STAT);

  always_comb begin
    cmp_d = cmp_q;
    inh_d = inh_q;
    arm_d = arm_q;
    clr_o = '0;
    for (int i = 0; i < int'(NCH); i++) begin
      if (wr_en_i && (addr_i == AW'(2 * i))) begin
        cmp_d[i][CW-1:DW] = wdata_i[CW-DW-1:0];
        inh_d[i]          = 1'b1;
      end
      if (wr_en_i && (addr_i == AW'(2 * i + 1))) begin
        cmp_d[i][DW-1:0] = wdata_i;
        inh_d[i]         = 1'b0;
        clr_o[i]         = arm_q[i];
        arm_d[i]         = 1'b0;
      end
      if (rd_stat && flag_i[i]) begin
        arm_d[i] = 1'b1;
      end
    end
  end

  always_comb begin
    oe_d  = oe_q;
    lvl_d = lvl_q;
    ie_d  = ie_q;
    if (wr_ctrl) begin
      oe_d  = wdata_i[NCH-1:0];
      lvl_d = wdata_i[2*NCH-1:NCH];
      ie_d  = wdata_i[DW-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
      inh_q <= '0;
      oe_q  <= '0;
      lvl_q <= '0;
      ie_q  <= 1'b0;
      arm_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      inh_q <= inh_d;
      oe_q  <= oe_d;
      lvl_q <= lvl_d;
      ie_q  <= ie_d;
      arm_q <= arm_d;
    end
  end

  assign force_o   = wr_force ? wdata_i[NCH-1:0] : '0;
  assign cmp_o     = cmp_q;
  assign inhibit_o = inh_q;
  assign oe_o      = oe_q;
  assign lvl_o     = lvl_q;
  assign ie_o      = ie_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < int'(NCH); i++) begin
      if (addr_i == AW'(2 * i))     rdata_o = cmp_q[i][CW-1:DW];
      if (addr_i == AW'(2 * i + 1)) rdata_o = cmp_q[i][DW-1:0];
    end
    if (addr_i == A_CTRL) begin
      rdata_o[NCH-1:0]     = oe_q;
      rdata_o[2*NCH-1:NCH] = lvl_q;
      rdata_o[DW-1]        = ie_q;
    end
    if (addr_i == A_STAT) rdata_o[NCH-1:0] = flag_i;
  end
endmodule

// File: rtl/occ_chan.sv
`timescale 1ns/1ps
module occ_chan
  import occ_pkg::*;
#(
  parameter int unsigned CW = OCC_CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          slow_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          inhibit_i,
  input  logic          oe_i,
  input  logic          lvl_i,
  input  logic          force_i,
  input  logic          lock_i,
  input  logic          clr_i,
  output logic          flag_o,
  output logic          pin_o
);
  logic [CW-1:0] ref_val;
  logic          hit, hit_q, hit_ev, frc;
  logic          flag_q, flag_d, lat_q, lat_d;

  // slow counter clocks match one count later, wrapping at the top
  assign ref_val = slow_i ? (cmp_i + CW'(1)) : cmp_i;
  assign hit     = (cnt_i == ref_val) && !inhibit_i;
  assign hit_ev  = hit && !hit_q;
  assign frc     = force_i && !lock_i && oe_i;

  always_comb begin
    flag_d = flag_q;
    lat_d  = lat_q;
    if (hit_ev)     flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    if ((hit_ev && oe_i) || frc) lat_d = lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      hit_q  <= hit;
      flag_q <= flag_d;
      lat_q  <= lat_d;
    end
  end

  assign flag_o = flag_q;
  assign pin_o  = oe_i && lat_q;

  // R2
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(hit_ev));
  // R4
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> !$rose(flag_q));
  // R5
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> $stable(lat_q));
  // R6
  force_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !hit_ev) |=> !$rose(flag_q));
  // R7
  lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !hit_ev) |=> $stable(lat_q));
endmodule

// File: rtl/occ_unit.sv
`timescale 1ns/1ps
module occ_unit
  import occ_pkg::*;
#(
  parameter int unsigned NCH = OCC_NCH,
  parameter int unsigned CW  = OCC_CW,
  parameter int unsigned DW  = OCC_DW,
  parameter int unsigned AW  = OCC_AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [CW-1:0]  cnt_i,
  input  logic           slow_clk_i,
  input  logic           mode_lock_i,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] ocmp_o,
  output logic           irq_o
);
  logic [1:0]             rst_sync_q;
  logic                   rst_n;
  logic [NCH-1:0][CW-1:0] cmp;
  logic [NCH-1:0]         inhibit, oe, lvl, frc, clr, flag;
  logic                   ie;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  occ_regs #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .flag_i    (flag),
    .rdata_o   (rdata_o),
    .cmp_o     (cmp),
    .inhibit_o (inhibit),
    .oe_o      (oe),
    .lvl_o     (lvl),
    .ie_o      (ie),
    .force_o   (frc),
    .clr_o     (clr)
  );

  for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
    occ_chan #(.CW(CW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .cnt_i     (cnt_i),
      .slow_i    (slow_clk_i),
      .cmp_i     (cmp[g]),
      .inhibit_i (inhibit[g]),
      .oe_i      (oe[g]),
      .lvl_i     (lvl[g]),
      .force_i   (frc[g]),
      .lock_i    (mode_lock_i),
      .clr_i     (clr[g]),
      .flag_o    (flag[g]),
      .pin_o     (ocmp_o[g])
    );
  end

  assign irq_o = ie && (|flag);

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (flag != '0));
endmodule

// File: tb/occ_unit_tb.sv
`timescale 1ns/1ps
module occ_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        slow_clk_i = 1'b0;
  logic        mode_lock_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [1:0]  ocmp_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         kind;   // 0 pins, 1 irq, 2 read data
    string      req;
    logic [7:0] exp;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  occ_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_i(cnt_i), .slow_clk_i(slow_clk_i),
    .mode_lock_i(mode_lock_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ocmp_o(ocmp_o), .irq_o(irq_o)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = {6'b0, ocmp_o};
        1:       act = {7'b0, irq_o};
        default: act = rdata_o;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(int kind, string req, logic [7:0] exp);
    item_t it;
    it.kind = kind; it.req = req; it.exp = exp;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    tick(); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    tick(); wr_en_i = 1'b0;
  endtask

  task automatic rd_status();
    tick(); rd_en_i = 1'b1; addr_i = 3'd6;
    tick(); rd_en_i = 1'b0;
  endtask

  task automatic set_cnt(logic [15:0] v);
    tick(); cnt_i = v;
    tick();
  endtask

  task automatic peek(logic [2:0] a, string req, logic [7:0] exp);
    addr_i = a;
    push(2, req, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (3) tick();

    // R1 reset state
    push(0, "R1", 8'h00);
    push(1, "R1", 8'h00);
    peek(3'd0, "R1", 8'hFF);
    peek(3'd1, "R1", 8'hFF);
    peek(3'd6, "R1", 8'h00);

    // oe0, oe1, lvl0, ie
    wr(3'd4, 8'h87);

    // R4 high byte write blocks matching
    wr(3'd0, 8'h00);
    set_cnt(16'h00FF);
    peek(3'd6, "R4", 8'h00);
    push(0, "R4", 8'h00);

    // R2 match at the compare value
    wr(3'd1, 8'h40);
    set_cnt(16'h0040);
    push(0, "R2", 8'h01);
    peek(3'd6, "R2", 8'h01);
    push(1, "R9", 8'h01);

    // R10 low write without a status read keeps the flag
    wr(3'd1, 8'h40);
    peek(3'd6, "R10", 8'h01);
    rd_status();
    wr(3'd1, 8'h40);
    peek(3'd6, "R10", 8'h00);
    // R11 counter still matches: no second set
    tick(); tick();
    peek(3'd6, "R11", 8'h00);
    push(1, "R11", 8'h00);

    // R3 slow clock matches one count later
    tick(); slow_clk_i = 1'b1;
    wr(3'd2, 8'h02);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h8F);
    set_cnt(16'h0200);
    peek(3'd6, "R3", 8'h00);
    set_cnt(16'h0201);
    peek(3'd6, "R3", 8'h02);
    push(0, "R3", 8'h03);

    // R6 force copies level without flag
    wr(3'd4, 8'h8B);
    wr(3'd5, 8'h01);
    push(0, "R6", 8'h02);
    peek(3'd6, "R6", 8'h02);
    // R8 force register reads zero
    peek(3'd5, "R8", 8'h00);

    // R7 lock blocks forcing
    tick(); mode_lock_i = 1'b1;
    wr(3'd4, 8'h8F);
    wr(3'd5, 8'h01);
    push(0, "R7", 8'h02);
    tick(); mode_lock_i = 1'b0;

    // R5 output disabled: flag sets, latch untouched
    slow_clk_i = 1'b0;
    wr(3'd4, 8'h8E);
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h00);
    set_cnt(16'h0300);
    push(0, "R5", 8'h02);
    peek(3'd6, "R5", 8'h03);
    wr(3'd4, 8'h8F);
    push(0, "R5", 8'h02);

    // R9 interrupt enable off
    wr(3'd4, 8'h0F);
    push(1, "R9", 8'h00);

    // R3 wrap: compare 0xFFFF matches count 0x0000 in slow mode
    tick(); slow_clk_i = 1'b1;
    wr(3'd2, 8'hFF);
    rd_status();
    wr(3'd3, 8'hFF);
    peek(3'd6, "R10", 8'h01);
    wr(3'd4, 8'h87);
    set_cnt(16'hFFFF);
    peek(3'd6, "R3", 8'h01);
    set_cnt(16'h0000);
    peek(3'd6, "R3", 8'h03);
    push(0, "R3", 8'h00);
    push(1, "R9", 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule